// File: doc/BRIEF.md
# Flyback Switching Cycle Timer

This block produces the gate drive for a primary-side flyback converter, one switching cycle at a time. At each turn-on it takes a snapshot of the on-time and off-time requested by the regulation loop and of a load-level code. From the load level it picks one of three modes: pulse-frequency mode at light load, fixed-timing PWM in the middle, and valley turn-on at heavy load. The snapshot then governs that whole cycle, so the loop can update its requests at any moment.

The on phase ends when the on-time count runs out or when the peak-current comparator fires, whichever comes first. A comparator trip cuts only the current pulse. The off phase always waits for the falling edge of the auxiliary winding, which marks the end of transformer reset. That wait is bounded. After the edge, the block either runs out the requested off-time or waits for a drain valley. In both cases a floor on the period caps the switching frequency, and valleys that come too early are skipped. If the reset edge never arrives, the block turns on anyway and reports a timeout.

Top module: `flyback_cycle_timer`

## Requirements
- R1: While `rst` is high, `gate`, `ilim_hit` and `rst_timeout` are low. `gate` goes high after the first clock edge at which `rst` is sampled low.
- R2: The gate stays high for exactly N clock cycles, where N is the on-time sampled at turn-on. A sampled value of 0 is treated as 1.
- R3: If `ipk_trip` is sampled high while the gate is high, the gate is low after that same edge. `ilim_hit` then stays high until the next turn-on, where it clears. The next cycle starts with its full on-time.
- R4: After the gate falls, it does not rise again before `knee` has been sampled high. In PWM and PFM modes the period is max(knee index + 2, on cycles + off-time, MIN_PERIOD). Here the knee index counts cycles from turn-on, and an off-time of 0 acts as 1.
- R5: If `knee` has not been sampled within RST_LIMIT = (CLK_HZ/1000)*TRST_MAX_US/1000 cycles after the gate falls, the gate rises after exactly RST_LIMIT off cycles. `rst_timeout` is high from that turn-on until the next one. A knee sampled on the last of those cycles takes precedence over the timeout.
- R6: In valley mode (`load_code` > VALLEY_ABOVE), once the knee has been seen, the gate rises on the edge after a `valley` pulse is sampled. The requested off-time is ignored.
- R7: A valley pulse sampled before MIN_PERIOD - 1 cycles have passed since turn-on is skipped. MIN_PERIOD = CLK_HZ / FSW_MAX_HZ.
- R8: Two consecutive gate rising edges are never fewer than MIN_PERIOD cycles apart.
- R9: In PFM mode (`load_code` < PFM_BELOW), the cycle uses `pfm_ton` and `pfm_toff` in place of `ton_req` and `toff_req`. Any other code below the valley threshold selects PWM mode.
- R10: Changes to mode, on-time and off-time inputs after a turn-on have no effect on the cycle already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_code | input | LOAD_W | Load level code |
| ton_req | input | TW | PWM/valley on-time request, cycles |
| toff_req | input | TW | PWM off-time request, cycles |
| pfm_ton | input | TW | PFM on-time (from line), cycles |
| pfm_toff | input | TW | PFM off-time (from load), cycles |
| ipk_trip | input | 1 | Peak-current comparator flag |
| knee | input | 1 | Aux-sense falling edge pulse |
| valley | input | 1 | Drain valley pulse |
| gate | output | 1 | Registered gate drive |
| ilim_hit | output | 1 | Current limit cut this cycle |
| rst_timeout | output | 1 | Cycle started by reset timeout |

## Verification
Two events can fall on the same edge: the reset edge arriving, and the bounded knee wait running out. A vector places the knee pulse on the last allowed off cycle. The bench then expects the knee to win, which means no timeout flag and a turn-on governed by the off-time rather than an immediate restart. Neighbouring vectors omit the knee entirely and must show the flag and a period of exactly on cycles plus RST_LIMIT.

// File: rtl/fct_pkg.sv
package fct_pkg;

    typedef enum logic [1:0] {
        MODE_PFM    = 2'd0,
        MODE_PWM    = 2'd1,
        MODE_VALLEY = 2'd2
    } fct_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ON     = 3'd1,
        ST_KNEE   = 3'd2,
        ST_HOLD   = 3'd3,
        ST_VALLEY = 3'd4
    } fct_state_e;

    typedef struct packed {
        logic turn_on;
        logic turn_off;
    } fct_edge_t;

    function automatic int unsigned min_period_ticks(input int unsigned clk_hz,
                                                     input int unsigned fmax_hz);
        return clk_hz / fmax_hz;
    endfunction

    function automatic int unsigned reset_ticks(input int unsigned clk_hz,
                                                input int unsigned max_us);
        return ((clk_hz / 1000) * max_us) / 1000;
    endfunction

endpackage

// File: rtl/fct_mode_sel.sv
module fct_mode_sel
    import fct_pkg::*;
#(
    parameter int TW           = 16,
    parameter int LOAD_W       = 4,
    parameter int PFM_BELOW    = 2,
    parameter int VALLEY_ABOVE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch,
    input  logic [LOAD_W-1:0] load_code,
    input  logic [TW-1:0]     ton_req,
    input  logic [TW-1:0]     toff_req,
    input  logic [TW-1:0]     pfm_ton,
    input  logic [TW-1:0]     pfm_toff,
    output fct_mode_e         mode_q,
    output logic [TW-1:0]     ton_q,
    output logic [TW-1:0]     toff_q
);

    fct_mode_e     mode_d;
    logic [TW-1:0] ton_raw;
    logic [TW-1:0] toff_raw;
    logic [TW-1:0] ton_d;
    logic [TW-1:0] toff_d;

    always_comb begin
        if (load_code < LOAD_W'(PFM_BELOW)) begin
            mode_d = MODE_PFM;
        end else if (load_code > LOAD_W'(VALLEY_ABOVE)) begin
            mode_d = MODE_VALLEY;
        end else begin
            mode_d = MODE_PWM;
        end
        ton_raw  = (mode_d == MODE_PFM) ? pfm_ton  : ton_req;
        toff_raw = (mode_d == MODE_PFM) ? pfm_toff : toff_req;
        ton_d    = (ton_raw  == '0) ? TW'(1) : ton_raw;
        toff_d   = (toff_raw == '0) ? TW'(1) : toff_raw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_PWM;
            ton_q  <= TW'(1);
            toff_q <= TW'(1);
        end else if (latch) begin
            mode_q <= mode_d;
            ton_q  <= ton_d;
            toff_q <= toff_d;
        end
    end

    // R2
    ton_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        ton_q != '0);

endmodule

// File: rtl/fct_tick_counters.sv
module fct_tick_counters
    import fct_pkg::*;
#(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  fct_edge_t     edges,
    output logic [CW-1:0] seg,
    output logic [CW-1:0] pcnt
);

    localparam logic [CW-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            seg  <= '0;
            pcnt <= '0;
        end else begin
            if (edges.turn_on || edges.turn_off) begin
                seg <= '0;
            end else if (seg != TOP) begin
                seg <= seg + CW'(1);
            end
            if (edges.turn_on) begin
                pcnt <= '0;
            end else if (pcnt != TOP) begin
                pcnt <= pcnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/fct_cycle_fsm.sv
module fct_cycle_fsm
    import fct_pkg::*;
#(
    parameter int TW         = 16,
    parameter int CW         = 17,
    parameter int MIN_PERIOD = 1538,
    parameter int RST_LIMIT  = 15000
) (
    input  logic          clk,
    input  logic          rst,
    input  fct_mode_e     mode,
    input  logic [TW-1:0] ton,
    input  logic [TW-1:0] toff,
    input  logic [CW-1:0] seg,
    input  logic [CW-1:0] pcnt,
    input  logic          ipk_trip,
    input  logic          knee,
    input  logic          valley,
    output fct_edge_t     edges,
    output logic          gate,
    output logic          ilim_hit,
    output logic          rst_timeout
);

    localparam logic [CW-1:0] PER_M1 = CW'(MIN_PERIOD - 1);
    localparam logic [CW-1:0] RST_M1 = CW'(RST_LIMIT - 1);

    fct_state_e    st;
    fct_state_e    nxt;
    logic          trip_cut;
    logic          tmo_evt;
    logic [CW-1:0] ton_m1;
    logic [CW-1:0] toff_m1;
    logic          per_ok;

    assign ton_m1  = CW'(ton)  - CW'(1);
    assign toff_m1 = CW'(toff) - CW'(1);
    assign per_ok  = (pcnt >= PER_M1);

    always_comb begin
        nxt      = st;
        edges    = '0;
        trip_cut = 1'b0;
        tmo_evt  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                nxt           = ST_ON;
                edges.turn_on = 1'b1;
            end
            ST_ON: begin
                if (ipk_trip || (seg >= ton_m1)) begin
                    nxt            = ST_KNEE;
                    edges.turn_off = 1'b1;
                    trip_cut       = ipk_trip;
                end
            end
            ST_KNEE: begin
                if (knee) begin
                    nxt = (mode == MODE_VALLEY) ? ST_VALLEY : ST_HOLD;
                end else if (seg >= RST_M1) begin
                    nxt           = ST_ON;
                    edges.turn_on = 1'b1;
                    tmo_evt       = 1'b1;
                end
            end
            ST_HOLD: begin
                if ((seg >= toff_m1) && per_ok) begin
                    nxt           = ST_ON;
                    edges.turn_on = 1'b1;
                end
            end
            ST_VALLEY: begin
                if (valley && per_ok) begin
                    nxt           = ST_ON;
                    edges.turn_on = 1'b1;
                end
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            gate        <= 1'b0;
            ilim_hit    <= 1'b0;
            rst_timeout <= 1'b0;
        end else begin
            st   <= nxt;
            gate <= (nxt == ST_ON);
            if (edges.turn_on) begin
                ilim_hit    <= 1'b0;
                rst_timeout <= tmo_evt;
            end else if (trip_cut) begin
                ilim_hit <= 1'b1;
            end
        end
    end

    // R3
    ilim_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (gate && ipk_trip) |=> !gate);

    // R3
    ilim_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate) |-> !ilim_hit);

    // R5
    tmo_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_timeout) |-> $rose(gate));

    // R5
    knee_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_KNEE) |-> (seg < CW'(RST_LIMIT)));

    // R6
    valley_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_VALLEY && !valley) |=> !gate);

endmodule

// File: rtl/flyback_cycle_timer.sv
module flyback_cycle_timer
    import fct_pkg::*;
#(
    parameter int CLK_HZ       = 200_000_000,
    parameter int FSW_MAX_HZ   = 130_000,
    parameter int TRST_MAX_US  = 75,
    parameter int TW           = 16,
    parameter int LOAD_W       = 4,
    parameter int PFM_BELOW    = 2,
    parameter int VALLEY_ABOVE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LOAD_W-1:0] load_code,
    input  logic [TW-1:0]     ton_req,
    input  logic [TW-1:0]     toff_req,
    input  logic [TW-1:0]     pfm_ton,
    input  logic [TW-1:0]     pfm_toff,
    input  logic              ipk_trip,
    input  logic              knee,
    input  logic              valley,
    output logic              gate,
    output logic              ilim_hit,
    output logic              rst_timeout
);

    localparam int MIN_PERIOD = int'(min_period_ticks(CLK_HZ, FSW_MAX_HZ));
    localparam int RST_LIMIT  = int'(reset_ticks(CLK_HZ, TRST_MAX_US));
    localparam int RW         = $clog2(RST_LIMIT + 1);
    localparam int CW         = ((RW > TW) ? RW : TW) + 1;

    fct_mode_e     mode_q;
    logic [TW-1:0] ton_q;
    logic [TW-1:0] toff_q;
    logic [CW-1:0] seg;
    logic [CW-1:0] pcnt;
    fct_edge_t     edges;

    fct_mode_sel #(
        .TW(TW), .LOAD_W(LOAD_W), .PFM_BELOW(PFM_BELOW), .VALLEY_ABOVE(VALLEY_ABOVE)
    ) u_mode (
        .clk(clk), .rst(rst), .latch(edges.turn_on),
        .load_code(load_code), .ton_req(ton_req), .toff_req(toff_req),
        .pfm_ton(pfm_ton), .pfm_toff(pfm_toff),
        .mode_q(mode_q), .ton_q(ton_q), .toff_q(toff_q)
    );

    fct_tick_counters #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .edges(edges), .seg(seg), .pcnt(pcnt)
    );

    fct_cycle_fsm #(
        .TW(TW), .CW(CW), .MIN_PERIOD(MIN_PERIOD), .RST_LIMIT(RST_LIMIT)
    ) u_fsm (
        .clk(clk), .rst(rst), .mode(mode_q), .ton(ton_q), .toff(toff_q),
        .seg(seg), .pcnt(pcnt), .ipk_trip(ipk_trip), .knee(knee), .valley(valley),
        .edges(edges), .gate(gate), .ilim_hit(ilim_hit), .rst_timeout(rst_timeout)
    );

    logic          gate_d;
    logic          rise_seen;
    logic [CW-1:0] per_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_d    <= 1'b0;
            rise_seen <= 1'b0;
            per_cnt   <= '0;
        end else begin
            gate_d <= gate;
            if (gate && !gate_d) begin
                rise_seen <= 1'b1;
                per_cnt   <= CW'(1);
            end else if (per_cnt != '1) begin
                per_cnt <= per_cnt + CW'(1);
            end
        end
    end

    // R8
    min_period_chk: assert property (@(posedge clk) disable iff (rst)
        (gate && !gate_d && rise_seen) |-> (per_cnt >= CW'(MIN_PERIOD)));

endmodule

// File: tb/flyback_cycle_timer_tb_top.sv
`timescale 1ns/1ps
module flyback_cycle_timer_tb_top;

    localparam int CLK_HZ = 2_000_000;
    localparam int TW     = 8;
    localparam int MINP   = CLK_HZ / 130_000;
    localparam int RSTL   = ((CLK_HZ / 1000) * 75) / 1000;
    localparam int NONE   = 255;
    localparam int NV     = 14;

    typedef struct packed {
        logic [3:0] ld;
        logic [7:0] ton;
        logic [7:0] toff;
        logic [7:0] pton;
        logic [7:0] ptoff;
        logic [7:0] trip;
        logic [7:0] knee;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{4'd5,  8'd6,  8'd12, 8'd0, 8'd0,  8'd255, 8'd8},
        '{4'd5,  8'd4,  8'd3,  8'd0, 8'd0,  8'd255, 8'd6},
        '{4'd5,  8'd5,  8'd6,  8'd0, 8'd0,  8'd255, 8'd30},
        '{4'd5,  8'd10, 8'd8,  8'd0, 8'd0,  8'd3,   8'd6},
        '{4'd5,  8'd10, 8'd8,  8'd0, 8'd0,  8'd255, 8'd12},
        '{4'd1,  8'd20, 8'd20, 8'd3, 8'd25, 8'd255, 8'd5},
        '{4'd12, 8'd5,  8'd0,  8'd0, 8'd0,  8'd255, 8'd6},
        '{4'd12, 8'd12, 8'd0,  8'd0, 8'd0,  8'd255, 8'd14},
        '{4'd5,  8'd5,  8'd10, 8'd0, 8'd0,  8'd255, 8'd255},
        '{4'd12, 8'd5,  8'd0,  8'd0, 8'd0,  8'd255, 8'd255},
        '{4'd5,  8'd0,  8'd10, 8'd0, 8'd0,  8'd255, 8'd2},
        '{4'd5,  8'd7,  8'd5,  8'd0, 8'd0,  8'd0,   8'd3},
        '{4'd5,  8'd6,  8'd12, 8'd0, 8'd0,  8'd255, 8'd8},
        '{4'd5,  8'd5,  8'd10, 8'd0, 8'd0,  8'd255, 8'd154}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    load_code = '0;
    logic [TW-1:0] ton_req = '0, toff_req = '0, pfm_ton = '0, pfm_toff = '0;
    logic          ipk_trip = 1'b0, knee = 1'b0, valley = 1'b0;
    logic          gate, ilim_hit, rst_timeout;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    flyback_cycle_timer #(.CLK_HZ(CLK_HZ), .TW(TW)) dut_i (
        .clk(clk), .rst(rst), .load_code(load_code),
        .ton_req(ton_req), .toff_req(toff_req), .pfm_ton(pfm_ton), .pfm_toff(pfm_toff),
        .ipk_trip(ipk_trip), .knee(knee), .valley(valley),
        .gate(gate), .ilim_hit(ilim_hit), .rst_timeout(rst_timeout)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        load_code = v.ld;
        ton_req   = v.ton;
        toff_req  = v.toff;
        pfm_ton   = v.pton;
        pfm_toff  = v.ptoff;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int prev_tmo;
        apply(VECS[0]);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 gate in reset", gate, 0);
        chk("R1 ilim_hit in reset", ilim_hit, 0);
        chk("R1 rst_timeout in reset", rst_timeout, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 gate after release", gate, 1);
        prev_tmo = 0;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int te, toe, ef, ep, etmo, f, p, kn, tr;
            bit vmode, pfm;
            string tg;
            v = VECS[i];
            chk("R5 timeout flag at turn-on", rst_timeout, prev_tmo);
            chk("R3 ilim cleared at turn-on", ilim_hit, 0);
            if (i < NV - 1) apply(VECS[i+1]);   // R10 change mid-cycle
            pfm   = (v.ld < 4'd2);
            vmode = (v.ld > 4'd8);
            te    = pfm ? int'(v.pton) : int'(v.ton);
            if (te == 0) te = 1;
            toe   = pfm ? int'(v.ptoff) : int'(v.toff);
            if (toe == 0) toe = 1;
            kn = int'(v.knee);
            tr = int'(v.trip);
            ef = (tr != NONE && tr < te) ? tr + 1 : te;
            etmo = 0;
            if (kn == NONE || kn > ef + RSTL - 1) begin
                ep = ef + RSTL;
                etmo = 1;
                tg = "R5 timeout period";
            end else if (vmode) begin
                int vv;
                vv = kn + 3;
                while (vv < MINP - 1) vv += 4;
                ep = vv + 1;
                tg = "R6/R7 valley period";
            end else begin
                ep = kn + 2;
                if (ef + toe > ep) ep = ef + toe;
                if (MINP > ep) ep = MINP;
                tg = pfm ? "R9 PFM period" : "R4/R8 off-time period";
            end
            f = -1;
            p = -1;
            for (int t = 0; t < 400; t++) begin
                if (t > 0) begin
                    if (gate == 1'b0 && f < 0) begin
                        f = t;
                        chk("R3 ilim_hit after gate off", ilim_hit,
                            (tr != NONE && tr < te) ? 1 : 0);
                    end
                    if (gate == 1'b1 && f >= 0) begin
                        p = t;
                        break;
                    end
                end
                ipk_trip = (t == tr);
                knee     = (t == kn);
                valley   = (kn != NONE) && (t >= kn + 3) && (((t - kn - 3) % 4) == 0);
                @(negedge clk);
            end
            ipk_trip = 1'b0;
            knee     = 1'b0;
            valley   = 1'b0;
            chk(pfm ? "R9/R10 on width" : ((tr != NONE) ? "R3 on width" : "R2/R10 on width"), f, ef);
            chk(tg, p, ep);
            prev_tmo = etmo;
        end
        chk("R5 timeout flag final", rst_timeout, prev_tmo);

        // R1 reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        chk("R1 gate after mid-run reset", gate, 0);
        chk("R1 flags after mid-run reset", ilim_hit | rst_timeout, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 gate restart", gate, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule